// File: doc/BRIEF.md
# Redundant-Stage Code Correction for a One-Bit-per-Stage Pipeline

This block turns the time-aligned decision bits of a 19-stage, one-bit-per-stage pipelined converter into a single corrected raw code. Most stages have a gain of two and give one binary weight each. Three unity-gain stages sit among them and carry no weight of their own. Each one, read together with the gain stage that follows it, tells whether the group of gain stages before it ran over or under its range. The block then adds or subtracts one unit at the weight of that group's least significant bit.

The 16 gain-stage bits form the base word, with the first stage as its MSB. The three signed corrections are summed with carries and borrows through all higher bits. The result is clamped to the 16-bit range instead of wrapping. It keeps the two trailing bits below the final 14-bit resolution for a later calibration adder. One register stage holds the result, and an output strobe follows the input strobe.

Top module: `redund_corr`

## Requirements
- R1: Stage k (k = 1..19) arrives on `stage_bits[19-k]`. The gain stages 1,2,3,5,6,7,8,10,11,12,13,15,16,17,18,19 map in that order onto `code_o[15]` down to `code_o[0]`. With no correction, the output equals that base word.
- R2: Overflow correction. When a redundant stage (4, 9 or 14) and the gain stage right after it both read 1, 2^W is added, with W = 13, 9 and 5 respectively.
- R3: Underflow correction. When a redundant stage and the gain stage right after it both read 0, 2^W is subtracted, with the same W as in R2.
- R4: When a redundant stage and its following gain stage differ, that pair applies no correction.
- R5: Corrections from several pairs are summed with the base word. Carries and borrows propagate through all higher-weight bits.
- R6: A sum above 65535 gives `code_o` = 16'hFFFF.
- R7: A sum below 0 gives `code_o` = 16'h0000.
- R8: `valid_o` equals `valid_i` delayed by one clock. `code_o` shows the result for the bits sampled on the same edge.
- R9: While `valid_i` is low, `code_o` holds its last value.
- R10: Synchronous active-high reset clears `code_o` to 0 and `valid_o` to 0 on the next edge.
- R11: Stages 18 and 19 appear unchanged on `code_o[1]` and `code_o[0]` unless the result is clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Stage bits are valid this cycle |
| stage_bits | input | 19 | Aligned decisions, stage k on bit 19-k |
| valid_o | output | 1 | Registered output strobe |
| code_o | output | 16 | Corrected raw code, clamped |

## Verification
The checker watches the following on every cycle:
- the one-cycle strobe latency;
- holding the code while the strobe is low;
- the reset values;
- clamping for the all-ones and all-zeros input words;
- the untouched trailing two bits on unclamped results.

The arithmetic of the corrections can only be shown by the bench scenarios. These cover the weight of each redundant pair, the signs for overflow and underflow, the no-op for mixed pairs, and carry or borrow chains when two or three pairs act together. The bench sweeps all 64 settings of the three pairs against many patterns of the remaining bits and compares each output with an arithmetic model.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int MAXS = 64;

  function automatic int count_gain_below(input logic [MAXS-1:0] mask, input int idx);
    int n;
    n = 0;
    for (int j = 0; j < MAXS; j++)
      if (j < idx && !mask[j]) n++;
    return n;
  endfunction

  function automatic int count_red(input logic [MAXS-1:0] mask);
    int n;
    n = 0;
    for (int j = 0; j < MAXS; j++)
      if (mask[j]) n++;
    return n;
  endfunction
endpackage

// File: rtl/rc_bit_router.sv
module rc_bit_router #(
  parameter int NSTG = 19,
  parameter logic [NSTG-1:0] RED_MASK = 19'h08420,
  parameter int OW = 16
) (
  input  logic [NSTG-1:0] bits,
  output logic [OW-1:0]   base
);
  localparam logic [rc_pkg::MAXS-1:0] M64 = rc_pkg::MAXS'(RED_MASK);

  for (genvar i = 0; i < NSTG; i++) begin : g_route
    if (!RED_MASK[i]) begin : g_gain
      assign base[rc_pkg::count_gain_below(M64, i)] = bits[i];
    end
  end
endmodule

// File: rtl/rc_pair_decode.sv
module rc_pair_decode #(
  parameter int SW = 18,
  parameter int W  = 0
) (
  input  logic                 red_bit,
  input  logic                 next_bit,
  output logic signed [SW-1:0] corr
);
  localparam logic signed [SW-1:0] STEP = SW'(1) << W;

  always_comb begin
    if (red_bit && next_bit)        corr = STEP;
    else if (!red_bit && !next_bit) corr = -STEP;
    else                            corr = '0;
  end
endmodule

// File: rtl/rc_sat_reg.sv
module rc_sat_reg #(
  parameter int OW = 16,
  parameter int SW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic signed [SW-1:0] sum,
  output logic                 valid_o,
  output logic [OW-1:0]        code_o
);
  localparam logic signed [SW-1:0] TOP = {{(SW-OW){1'b0}}, {OW{1'b1}}};

  logic [OW-1:0] clamped;

  always_comb begin
    if (sum < 0)        clamped = '0;
    else if (sum > TOP) clamped = '1;
    else                clamped = sum[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= clamped;
    end
  end
endmodule

// File: rtl/redund_corr.sv
module redund_corr #(
  parameter int NSTG = 19,
  parameter logic [NSTG-1:0] RED_MASK = 19'h08420,
  localparam int OW = NSTG - rc_pkg::count_red(rc_pkg::MAXS'(RED_MASK)),
  localparam int SW = OW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [NSTG-1:0] stage_bits,
  output logic            valid_o,
  output logic [OW-1:0]   code_o
);
  localparam logic [rc_pkg::MAXS-1:0] M64 = rc_pkg::MAXS'(RED_MASK);

  logic [OW-1:0]        base;
  logic signed [SW-1:0] corr [NSTG];
  logic signed [SW-1:0] sum;

  rc_bit_router #(.NSTG(NSTG), .RED_MASK(RED_MASK), .OW(OW)) u_route (
    .bits(stage_bits),
    .base(base)
  );

  for (genvar i = 0; i < NSTG; i++) begin : g_pair
    if (RED_MASK[i] && i > 0) begin : g_red
      rc_pair_decode #(.SW(SW), .W(rc_pkg::count_gain_below(M64, i))) u_dec (
        .red_bit (stage_bits[i]),
        .next_bit(stage_bits[i-1]),
        .corr    (corr[i])
      );
    end else begin : g_none
      assign corr[i] = '0;
    end
  end

  always_comb begin
    sum = {{(SW-OW){1'b0}}, base};
    for (int i = 0; i < NSTG; i++) sum = sum + corr[i];
  end

  rc_sat_reg #(.OW(OW), .SW(SW)) u_sat (
    .clk    (clk),
    .rst    (rst),
    .valid_i(valid_i),
    .sum    (sum),
    .valid_o(valid_o),
    .code_o (code_o)
  );
endmodule

// File: rtl/redund_corr_chk.sv
module redund_corr_chk #(
  parameter int NSTG = 19,
  parameter int OW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_i,
  input logic [NSTG-1:0] stage_bits,
  input logic            valid_o,
  input logic [OW-1:0]   code_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(rst) |-> (valid_o == $past(valid_i)));

  a_r9_hold_code: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(valid_i)) |-> $stable(code_o));

  a_r10_reset_state: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (code_o == '0 && !valid_o));

  a_r6_clamp_high: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(valid_i) && $past(stage_bits) == '1) |-> (code_o == '1));

  a_r7_clamp_low: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(valid_i) && $past(stage_bits) == '0) |-> (code_o == '0));

  a_r11_trailing_bits: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(valid_i) && code_o != '1 && code_o != '0)
      |-> (code_o[1:0] == $past(stage_bits[1:0])));
endmodule

bind redund_corr redund_corr_chk #(.NSTG(NSTG), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .stage_bits(stage_bits),
  .valid_o(valid_o), .code_o(code_o)
);

// File: tb/redund_corr_test.sv
`timescale 1ns/1ps
module redund_corr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [18:0] stage_bits = '0;
  logic        valid_o;
  logic [15:0] code_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  redund_corr uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .stage_bits(stage_bits),
    .valid_o(valid_o), .code_o(code_o)
  );

  function automatic logic sb(input logic [18:0] b, input int k);
    return b[19-k];
  endfunction

  function automatic int corr_of(input logic [18:0] b, input int s);
    if (sb(b, s) && sb(b, s+1))   return 1;
    if (!sb(b, s) && !sb(b, s+1)) return -1;
    return 0;
  endfunction

  function automatic int model_sum(input logic [18:0] b);
    int base, p;
    base = 0; p = 15;
    for (int k = 1; k <= 19; k++) begin
      if (k != 4 && k != 9 && k != 14) begin
        if (sb(b, k)) base += (1 << p);
        p--;
      end
    end
    return base + corr_of(b, 4) * 8192 + corr_of(b, 9) * 512 + corr_of(b, 14) * 32;
  endfunction

  function automatic logic [15:0] clampf(input int s);
    if (s > 65535) return 16'hFFFF;
    if (s < 0) return 16'h0000;
    return 16'(s);
  endfunction

  function automatic string tag_of(input logic [18:0] b);
    int s, n, c;
    s = model_sum(b);
    if (s > 65535) return "R6";
    if (s < 0) return "R7";
    n = 0; c = 0;
    for (int s2 = 4; s2 <= 14; s2 += 5) begin
      if (corr_of(b, s2) != 0) begin n++; c = corr_of(b, s2); end
    end
    if (n >= 2) return "R5";
    if (n == 1) return (c > 0) ? "R2" : "R3";
    return "R1/R4";
  endfunction

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [18:0] b);
    logic [15:0] e;
    stage_bits = b;
    valid_i = 1'b1;
    @(posedge clk); #1;
    e = clampf(model_sum(b));
    check16(tag_of(b), code_o, e);
    check16("R8", {15'd0, valid_o}, 16'd1);
    if (e != 16'hFFFF && e != 16'h0000)
      check16("R11", {14'd0, code_o[1:0]}, {14'd0, b[1:0]});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    logic [18:0] b;
    logic [31:0] x;
    rst = 1'b1; valid_i = 1'b1; stage_bits = '1;
    @(posedge clk); @(posedge clk); #1;
    check16("R10", code_o, 16'h0000);
    check16("R10", {15'd0, valid_o}, 16'd0);
    rst = 1'b0;

    apply(19'h7FFFF);
    apply(19'h00000);
    apply(19'b000_1_0_000_1_0_000_1_0_0000);
    apply(19'b111_0_1_111_0_1_111_0_1_1111);

    for (int c = 0; c < 64; c++) begin
      for (int j = 0; j < 512; j++) begin
        x = 32'(j) * 32'h9E3779B1 + 32'(c) * 32'h7F4A7C15 + 32'(j);
        b = x[31:13];
        b[15] = c[0]; b[14] = c[1];
        b[10] = c[2]; b[9]  = c[3];
        b[5]  = c[4]; b[4]  = c[5];
        apply(b);
      end
    end

    apply(19'h2AAAA);
    held = code_o;
    valid_i = 1'b0;
    stage_bits = 19'h55555;
    @(posedge clk); #1;
    check16("R9", code_o, held);
    check16("R8", {15'd0, valid_o}, 16'd0);
    stage_bits = 19'h7FFFF;
    @(posedge clk); #1;
    check16("R9", code_o, held);

    apply(19'h3C3C3);
    rst = 1'b1; valid_i = 1'b1;
    @(posedge clk); #1;
    check16("R10", code_o, 16'h0000);
    check16("R10", {15'd0, valid_o}, 16'd0);
    rst = 1'b0;
    apply(19'h12345);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule